// File: doc/BRIEF.md
# Event Timestamp Capture Unit

This block stores the value of a free-running 32-bit cycle counter at the moment a chosen edge appears on an asynchronous event pin. The pin is first brought into the clock domain by a flop chain, then an edge detector decides whether the selected polarity has occurred. Only one capture channel exists, and only one polarity is active at any time.

Software talks to the block through a small register file of 16-bit words. There is one configuration word, one status word, the stored count split into a low word and a high word, and a read-only word that gives the counter clock period in picoseconds. The normal flow has four steps. Software polls the status word until the valid flag reads 1. It then reads the low word and the high word. Finally it writes the status word with the valid bit at 0, which re-arms the channel. If an event arrives while a result is still waiting, the block raises a separate miss flag instead of silently losing the event, unless overwrite mode has been chosen. A saturating counter counts the accepted events, and any write to the configuration or status word clears it.

Register map (3-bit word address):

| Address | Word |
|---------|------|
| 0 | configuration |
| 1 | status |
| 2 | stored count, bits 15:0 |
| 3 | stored count, bits 31:16 |
| 4 | clock period in ps (read-only) |
| 5–7 | unmapped, read as 0 |

Configuration bits: bit 0 falling-edge select, bit 1 overwrite enable, bit 2 event-count enable.

Status bits: bit 0 valid, bit 1 miss, bits 5:2 event count.

Top module: `evt_stamp_unit`

## Requirements
- R1: After a synchronous active-low reset, the configuration, status and stored-count words read 0. Address 4 reads the period parameter (default 8000). Addresses 5 to 7 read 0.
- R2: With configuration bit 0 clear, a rising edge on `evt_pin` is captured. If the pin changes just before clock edge k, the `cyc_count` value present in the cycle before edge k+2 is stored, and status bit 0 (valid) reads 1 after edge k+2.
- R3: With configuration bit 0 set, only falling edges are captured. The edge that is not selected changes no status or stored-count bit.
- R4: Address 2 returns bits 15:0 of the stored count and address 3 returns bits 31:16.
- R5: When an edge arrives while valid is 1 and configuration bit 1 (overwrite) is 0, status bit 1 (miss) becomes 1. The stored count and the event count stay unchanged.
- R6: When overwrite is 1, an edge that arrives while valid is 1 replaces the stored count and leaves the miss bit unchanged.
- R7: A write to address 1 clears valid when data bit 0 is 0 and keeps it when that bit is 1. It clears miss when data bit 1 is 0. Valid becomes 1 only through a capture, and once cleared the next selected edge is captured.
- R8: When configuration bit 2 is 1, each captured event adds one to the event count in status bits 5:2, and the count stops at 15. When bit 2 is 0, the count does not change.
- R9: Any write to address 0 or address 1 sets the event count to 0. A write to address 0 does not change valid, miss or the stored count.
- R10: Address 4 is read-only, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all flops |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_pin | input | 1 | Asynchronous external event input |
| cyc_count | input | 32 | Free-running cycle counter value to be stored |
| reg_addr | input | 3 | Register word address |
| reg_wen | input | 1 | Write strobe, acts on the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |

## Verification
The hardest case to reach from the ports is the event counter at its ceiling. Getting there takes more than fifteen accepted captures with no clearing write in between, so the stimulus turns on overwrite and counting and then drives seventeen rising edges in a row. The miss path also needs care, because it only shows up when an edge arrives while a result is still unread. The vector table therefore orders its entries so that an edge falls in that window, and then checks that the stored count read back is the older value. Capture latency is checked by changing `cyc_count` on every cycle around the edge, so that only the value from the intended cycle can match.

// File: rtl/evt_stamp_pkg.sv
// Shared definitions for the event timestamp capture unit: register
// addresses, configuration and status bit positions, configuration type.
package evt_stamp_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        ADDR_CFG    = 3'd0,
        ADDR_STAT   = 3'd1,
        ADDR_TS_LO  = 3'd2,
        ADDR_TS_HI  = 3'd3,
        ADDR_PERIOD = 3'd4
    } reg_addr_e;

    localparam int CFG_FALL_BIT = 0;
    localparam int CFG_OVR_BIT  = 1;
    localparam int CFG_CNT_BIT  = 2;
    localparam int CFG_W        = 3;

    localparam int ST_VALID_BIT = 0;
    localparam int ST_MISS_BIT  = 1;
    localparam int ST_CNT_LSB   = 2;

    typedef struct packed {
        logic cnt_en;
        logic ovr_en;
        logic fall_sel;
    } cfg_t;

endpackage

// File: rtl/evt_sync_edge.sv
// Brings the asynchronous event pin into the clock domain through a
// SYNC_STAGES-deep flop chain, then flags the selected edge for one cycle.
// Assumes the pin is low while reset is asserted (the chain resets to 0).
module evt_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic fall_sel_i,
    output logic evt_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    // Metastability chain: shift the raw pin in at the low end.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
            end
        end
    endgenerate

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // Edge pulse of the polarity chosen by the configuration.
    always_comb begin
        if (fall_sel_i) evt_o = prev_q & ~cur;
        else            evt_o = ~prev_q & cur;
    end

endmodule

// File: rtl/evt_capture_core.sv
// Holds the stored count, the valid and miss flags and the saturating event
// counter. A status write takes effect before a coincident event is judged.
// Assumes evt_i is a single-cycle pulse per edge.
module evt_capture_core #(
    parameter int TS_W  = 32,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic [TS_W-1:0]  cyc_i,
    input  logic             ovr_en_i,
    input  logic             cnt_en_i,
    input  logic             sts_wr_i,
    input  logic             keep_valid_i,
    input  logic             keep_miss_i,
    input  logic             cnt_clr_i,
    output logic             valid_o,
    output logic             miss_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [TS_W-1:0]  ts_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             valid_q, miss_q;
    logic [CNT_W-1:0] cnt_q;
    logic [TS_W-1:0]  ts_q;
    logic             valid_after_wr, miss_after_wr;
    logic             accept, missed;
    logic [CNT_W-1:0] cnt_base;

    // Flags after any software write of this cycle, then event judgement.
    always_comb begin
        valid_after_wr = valid_q & ~(sts_wr_i & ~keep_valid_i);
        miss_after_wr  = miss_q  & ~(sts_wr_i & ~keep_miss_i);
        accept         = evt_i & (~valid_after_wr | ovr_en_i);
        missed         = evt_i & valid_after_wr & ~ovr_en_i;
        cnt_base       = cnt_clr_i ? '0 : cnt_q;
    end

    // Valid and miss flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            miss_q  <= 1'b0;
        end else begin
            valid_q <= valid_after_wr | accept;
            miss_q  <= miss_after_wr | missed;
        end
    end

    // Stored count: loaded only on an accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n)      ts_q <= '0;
        else if (accept) ts_q <= cyc_i;
    end

    // Saturating event counter, cleared by configuration or status writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (accept && cnt_en_i && cnt_base != CNT_MAX)
            cnt_q <= cnt_base + 1'b1;
        else
            cnt_q <= cnt_base;
    end

    assign valid_o = valid_q;
    assign miss_o  = miss_q;
    assign cnt_o   = cnt_q;
    assign ts_o    = ts_q;

endmodule

// File: rtl/evt_regfile.sv
// Word-addressed register file: holds the configuration, decodes writes into
// strobes for the capture core, and multiplexes read data. Reads have no
// side effects. Assumes TS_W == 2*DW.
module evt_regfile
    import evt_stamp_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CNT_W     = 4,
    parameter int PERIOD_PS = 8000,
    localparam int TS_W     = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              valid_i,
    input  logic              miss_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [TS_W-1:0]   ts_i,
    output cfg_t              cfg_o,
    output logic              sts_wr_o,
    output logic              keep_valid_o,
    output logic              keep_miss_o,
    output logic              cnt_clr_o,
    output logic [DW-1:0]     reg_rdata
);

    cfg_t          cfg_q;
    logic          cfg_wr;
    logic [DW-1:0] stat_word;

    // Write decode for the two writable words.
    always_comb begin
        cfg_wr       = reg_wen && (reg_addr == ADDR_CFG);
        sts_wr_o     = reg_wen && (reg_addr == ADDR_STAT);
        keep_valid_o = reg_wdata[ST_VALID_BIT];
        keep_miss_o  = reg_wdata[ST_MISS_BIT];
        cnt_clr_o    = cfg_wr | sts_wr_o;
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_t'(reg_wdata[CFG_W-1:0]);
    end

    // Status word assembly.
    always_comb begin
        stat_word                         = '0;
        stat_word[ST_VALID_BIT]           = valid_i;
        stat_word[ST_MISS_BIT]            = miss_i;
        stat_word[ST_CNT_LSB +: CNT_W]    = cnt_i;
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        case (reg_addr)
            ADDR_CFG:    reg_rdata = DW'(cfg_q);
            ADDR_STAT:   reg_rdata = stat_word;
            ADDR_TS_LO:  reg_rdata = ts_i[DW-1:0];
            ADDR_TS_HI:  reg_rdata = ts_i[TS_W-1:DW];
            ADDR_PERIOD: reg_rdata = DW'(PERIOD_PS);
            default:     reg_rdata = '0;
        endcase
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/evt_stamp_unit.sv
// Top level of the event timestamp capture unit: synchroniser and edge
// detector, capture core, and register file. One channel, one polarity.
module evt_stamp_unit
    import evt_stamp_pkg::*;
#(
    parameter int DW          = 16,
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int PERIOD_PS   = 8000,
    localparam int TS_W       = 2 * DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pin,
    input  logic [TS_W-1:0]   cyc_count,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wen,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata
);

    cfg_t             cfg;
    logic             evt_pulse;
    logic             sts_wr, keep_valid, keep_miss, cnt_clr;
    logic             st_valid, st_miss;
    logic [CNT_W-1:0] st_cnt;
    logic [TS_W-1:0]  ts_q;

    evt_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (evt_pin),
        .fall_sel_i (cfg.fall_sel),
        .evt_o      (evt_pulse)
    );

    evt_capture_core #(.TS_W(TS_W), .CNT_W(CNT_W)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_pulse),
        .cyc_i        (cyc_count),
        .ovr_en_i     (cfg.ovr_en),
        .cnt_en_i     (cfg.cnt_en),
        .sts_wr_i     (sts_wr),
        .keep_valid_i (keep_valid),
        .keep_miss_i  (keep_miss),
        .cnt_clr_i    (cnt_clr),
        .valid_o      (st_valid),
        .miss_o       (st_miss),
        .cnt_o        (st_cnt),
        .ts_o         (ts_q)
    );

    evt_regfile #(.DW(DW), .CNT_W(CNT_W), .PERIOD_PS(PERIOD_PS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wen      (reg_wen),
        .reg_wdata    (reg_wdata),
        .valid_i      (st_valid),
        .miss_i       (st_miss),
        .cnt_i        (st_cnt),
        .ts_i         (ts_q),
        .cfg_o        (cfg),
        .sts_wr_o     (sts_wr),
        .keep_valid_o (keep_valid),
        .keep_miss_o  (keep_miss),
        .cnt_clr_o    (cnt_clr),
        .reg_rdata    (reg_rdata)
    );

endmodule

// File: rtl/evt_stamp_unit_chk.sv
// Assertion checker for evt_stamp_unit, attached by bind. Relates the edge
// pulse, the register-port writes and the capture state across cycles.
module evt_stamp_unit_chk #(
    parameter int TS_W  = 32,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       reg_addr,
    input logic             reg_wen,
    input logic             evt,
    input logic             ovr,
    input logic             valid,
    input logic             miss,
    input logic [CNT_W-1:0] cnt,
    input logic [TS_W-1:0]  ts
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic clr_wr, st_wr;
    assign st_wr  = reg_wen && (reg_addr == 3'd1);
    assign clr_wr = reg_wen && (reg_addr == 3'd0 || reg_addr == 3'd1);

    // R2: an accepted edge always leaves a valid result.
    p_capture_sets_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt && (!valid || ovr) |=> valid);

    // R5: a missed edge keeps the stored count and raises the miss flag.
    p_miss_keeps_ts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt && valid && !ovr && !st_wr |=> $stable(ts) && miss);

    // R6: in overwrite mode no miss is raised.
    p_ovr_no_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !miss && ovr |=> !miss);

    // R7: valid rises only through an edge pulse.
    p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid && !evt |=> !valid);

    // R8: a full counter stays full until cleared.
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt == CMAX && !clr_wr |=> cnt == CMAX);

    // R9: a clearing write with no coincident edge leaves a zero count.
    p_cnt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && !evt |=> cnt == '0);

endmodule

bind evt_stamp_unit evt_stamp_unit_chk #(.TS_W(TS_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_wen  (reg_wen),
    .evt      (evt_pulse),
    .ovr      (cfg.ovr_en),
    .valid    (st_valid),
    .miss     (st_miss),
    .cnt      (st_cnt),
    .ts       (ts_q)
);

// File: tb/evt_stamp_unit_tb.sv
`timescale 1ns/1ps
module evt_stamp_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pin = 1'b0;
    logic [31:0] cyc_count = '0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wen = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    evt_stamp_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pin   (evt_pin),
        .cyc_count (cyc_count),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    typedef struct packed {
        logic        wr_cfg;
        logic [2:0]  cfg;
        logic        clr;
        logic        lvl;
        logic [31:0] base;
        logic [15:0] exp_st;
        logic [31:0] exp_ts;
    } vec_t;

    // cfg bits: [0] falling select, [1] overwrite, [2] count enable.
    // status: [0] valid, [1] miss, [5:2] count.
    localparam vec_t VEC [10] = '{
        '{1'b1, 3'b100, 1'b0, 1'b1, 32'h1000_0000, 16'h0005, 32'h1000_0002}, // R2
        '{1'b0, 3'b100, 1'b0, 1'b0, 32'h2000_0000, 16'h0005, 32'h1000_0002}, // R3
        '{1'b0, 3'b100, 1'b0, 1'b1, 32'h3000_0000, 16'h0007, 32'h1000_0002}, // R5
        '{1'b0, 3'b100, 1'b1, 1'b0, 32'h4000_0000, 16'h0000, 32'h1000_0002}, // R7
        '{1'b0, 3'b100, 1'b0, 1'b1, 32'hABCD_0010, 16'h0005, 32'hABCD_0012}, // R7
        '{1'b1, 3'b110, 1'b0, 1'b0, 32'h6000_0000, 16'h0001, 32'hABCD_0012}, // R9
        '{1'b0, 3'b110, 1'b0, 1'b1, 32'h00FF_FFF0, 16'h0005, 32'h00FF_FFF2}, // R6
        '{1'b1, 3'b001, 1'b1, 1'b0, 32'h5555_AAA0, 16'h0001, 32'h5555_AAA2}, // R3 R8
        '{1'b0, 3'b001, 1'b0, 1'b1, 32'h7000_0000, 16'h0001, 32'h5555_AAA2}, // R3
        '{1'b0, 3'b001, 1'b1, 1'b1, 32'h8000_0000, 16'h0000, 32'h5555_AAA2}  // R7
    };

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wen   = 1'b1;
        @(negedge clk);
        reg_wen   = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        n_chk++;
        if (reg_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0d actual %h expected %h", tag, a, reg_rdata, exp);
        end
    endtask

    // Drive the pin level and a counter that changes every cycle around it.
    task automatic fire(input logic lvl, input logic [31:0] base);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (i == 0) evt_pin = lvl;
            cyc_count = base + 32'(i);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and unmapped read.
        rd_chk(3'd0, 16'h0000, "R1 cfg");
        rd_chk(3'd1, 16'h0000, "R1 status");
        rd_chk(3'd2, 16'h0000, "R1 ts_lo");
        rd_chk(3'd3, 16'h0000, "R1 ts_hi");
        rd_chk(3'd4, 16'd8000, "R1 period");
        rd_chk(3'd7, 16'h0000, "R1 unmapped");
        // R10: period word ignores writes.
        wr(3'd4, 16'h1234);
        rd_chk(3'd4, 16'd8000, "R10 period write");

        // Vector table: R2 R3 R4 R5 R6 R7 R8 R9.
        for (int v = 0; v < 10; v++) begin
            if (VEC[v].wr_cfg) wr(3'd0, {13'd0, VEC[v].cfg});
            if (VEC[v].clr)    wr(3'd1, 16'h0000);
            fire(VEC[v].lvl, VEC[v].base);
            rd_chk(3'd1, VEC[v].exp_st, $sformatf("R2 R3 R5 R6 R7 R8 R9 vec %0d status", v));
            rd_chk(3'd2, VEC[v].exp_ts[15:0], $sformatf("R4 vec %0d ts_lo", v));
            rd_chk(3'd3, VEC[v].exp_ts[31:16], $sformatf("R4 vec %0d ts_hi", v));
        end
        rd_chk(3'd0, 16'h0001, "R9 cfg readback");

        // R8: saturation at 15 with overwrite and counting on.
        wr(3'd0, 16'h0006);
        rd_chk(3'd1, 16'h0000, "R9 cfg write clears count and keeps valid");
        for (int n = 0; n < 17; n++) begin
            fire(1'b0, 32'h0000_0100);
            fire(1'b1, 32'h0000_0200 + 32'(n * 16));
        end
        rd_chk(3'd1, 16'h003D, "R8 saturated count");
        rd_chk(3'd2, 16'h0302, "R6 last overwrite lo");
        // R7 and R9: status write with bit0=1 keeps valid, clears count.
        wr(3'd1, 16'h0001);
        rd_chk(3'd1, 16'h0001, "R7 keep valid R9 clear count");

        // R1: reset in mid-run.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(3'd1, 16'h0000, "R1 status after reset");
        rd_chk(3'd0, 16'h0000, "R1 cfg after reset");
        rd_chk(3'd3, 16'h0000, "R1 ts_hi after reset");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule